// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block derives every digital drive clock of a two-output linear CCD from one fast system clock. Each line begins with a transfer event. The shift clocks are parked (phase-1 high, phase-2 and last-stage low) and the transfer gate is pulsed, with a guard interval on either side. Then comes a readout train. In that train phase-1 toggles once per half-period, and each half-period carries one reset-gate pulse and, optionally, one clamp pulse. Each half-period moves one odd and one even pixel to the two outputs.

All widths, guard intervals and the number of half-periods are elaboration parameters counted in system clock ticks. The line period, which sets integration time, is a runtime input. A clamp-mode input selects per-pixel clamping or a quiet clamp line. That input is captured only when a line begins. A one-cycle line-start strobe lets downstream capture logic align to each line. All outputs leave the block from one register stage, so their relative timing is exact to the tick.

Top module: `ccd_clkgen`

## Requirements
- R1: While reset is asserted, and immediately after it is asserted asynchronously, the outputs read xfer_o=0, phi1_o=1, phi2_o=0, phi2l_o=0, rst_gate_o=0, clamp_o=0 and line_start_o=0.
- R2: line_start_o is a single-cycle pulse. Consecutive rises are max(line_period_i, 2*GUARD_TK + XFER_TK + NPIX*HALF_TK + 1) cycles apart, so a period shorter than one full transfer plus readout is stretched.
- R3: From the line_start_o rise until GUARD_TK cycles after xfer_o falls, phi1_o stays 1, phi2_o and phi2l_o stay 0, and rst_gate_o and clamp_o stay 0.
- R4: xfer_o rises exactly GUARD_TK cycles after line_start_o rises and stays high for exactly XFER_TK cycles.
- R5: phi1_o falls exactly GUARD_TK cycles after xfer_o falls. It then changes level every HALF_TK cycles, for NPIX half-periods per line.
- R6: phi2_o and phi2l_o always equal the inverse of phi1_o.
- R7: Each readout half-period carries one rst_gate_o pulse. The pulse rises RST_DLY_TK cycles after the phase edge that opens the half-period and lasts RST_TK cycles, giving NPIX pulses per line.
- R8: With clamp_mode_i=1 (per-pixel clamp), each reset pulse is followed by one clamp_o pulse. That pulse rises CLP_GAP_TK cycles after rst_gate_o falls and lasts CLP_TK cycles, and it never overlaps rst_gate_o.
- R9: With clamp_mode_i=0 (line clamp), clamp_o stays 0 for the whole line.
- R10: clamp_mode_i is captured only when a line starts. Changing it during a line does not change that line's clamp_o activity, and it takes effect from the next line.
- R11: After the last readout half-period, phi1_o stays 1 and rst_gate_o and clamp_o stay 0 until the next line starts, with no extra phase edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clamp_mode_i | input | 1 | 1 = clamp every pixel, 0 = clamp held low during readout |
| line_period_i | input | LP_W | Line period in ticks (integration time) |
| xfer_o | output | 1 | Transfer gate clock |
| phi1_o | output | 1 | Shift clock phase 1 |
| phi2_o | output | 1 | Shift clock phase 2 |
| phi2l_o | output | 1 | Last-stage shift clock |
| rst_gate_o | output | 1 | Reset gate clock |
| clamp_o | output | 1 | Reset-level clamp clock |
| line_start_o | output | 1 | One-cycle strobe at the start of each line |

## Verification
The bench programs line periods below, at and just above the minimum. A sequencer that restarted on the period alone would cut readout short, and the bench would see fewer reset pulses and a shorter line spacing. It measures each guard interval from the exact tick of the transfer edges, so an off-by-one exit from a guard phase shows up as a shifted first phase-1 fall. It flips the clamp mode in the middle of a line, where a design sampling the input continuously would clamp pixels it should not. It also counts phase edges after the last half-period, where an odd-ended train would add a spurious edge, and it applies an asynchronous reset during readout.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;

  typedef enum logic [2:0] {
    PH_HOLD = 3'd0,
    PH_PRE  = 3'd1,
    PH_XFER = 3'd2,
    PH_POST = 3'd3,
    PH_READ = 3'd4
  } phase_e;

  typedef struct packed {
    logic xfer;
    logic phi1;
    logic phi2;
    logic phi2l;
    logic rgate;
    logic clamp;
    logic lstart;
  } drv_s;

endpackage

// File: rtl/ccdt_rst_sync.sv
module ccdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/ccdt_line_timer.sv
module ccdt_line_timer #(
  parameter int LP_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LP_W-1:0] period_i,
  input  logic            idle_i,
  output logic            expire_o
);

  localparam logic [LP_W-1:0] CNT_MAX = {LP_W{1'b1}};

  logic [LP_W-1:0] lcnt_q;
  logic [LP_W-1:0] lcnt_d;
  logic [LP_W:0]   lcnt_p1;

  assign lcnt_p1  = {1'b0, lcnt_q} + (LP_W+1)'(1);
  // a line may restart only once the previous readout is finished
  assign expire_o = idle_i && (lcnt_p1 >= {1'b0, period_i});

  always_comb begin
    if (expire_o)
      lcnt_d = '0;
    else if (lcnt_q == CNT_MAX)
      lcnt_d = lcnt_q;
    else
      lcnt_d = lcnt_p1[LP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lcnt_q <= '0;
    else
      lcnt_q <= lcnt_d;
  end

endmodule

// File: rtl/ccdt_phase_seq.sv
module ccdt_phase_seq
  import ccdt_pkg::*;
#(
  parameter int GUARD_TK = 15,
  parameter int XFER_TK  = 75
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   expire_i,
  input  logic   mode_i,
  input  logic   read_done_i,
  input  logic   phi1_i,
  output phase_e phase_o,
  output logic   idle_o,
  output logic   run_o,
  output logic   xfer_o,
  output logic   lstart_o,
  output logic   bit_mode_o
);

  localparam int CMAX = (GUARD_TK > XFER_TK) ? GUARD_TK : XFER_TK;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_TK - 1);
  localparam logic [CW-1:0] XFER_LAST  = CW'(XFER_TK - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          mode_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    mode_en = 1'b0;
    unique case (phase_q)
      PH_HOLD: begin
        if (expire_i) begin
          phase_d = PH_PRE;
          cnt_d   = '0;
          mode_en = 1'b1;
        end
      end
      PH_PRE: begin
        if (cnt_q == GUARD_LAST) begin
          phase_d = PH_XFER;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_XFER: begin
        if (cnt_q == XFER_LAST) begin
          phase_d = PH_POST;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_POST: begin
        if (cnt_q == GUARD_LAST) begin
          phase_d = PH_READ;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_READ: begin
        if (read_done_i)
          phase_d = PH_HOLD;
      end
      default: begin
        phase_d = PH_HOLD;
        cnt_d   = '0;
      end
    endcase
  end

  assign mode_d = mode_en ? mode_i : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  assign phase_o    = phase_q;
  assign idle_o     = (phase_q == PH_HOLD);
  assign run_o      = (phase_q == PH_READ);
  assign xfer_o     = (phase_q == PH_XFER);
  assign lstart_o   = (phase_q == PH_PRE) && (cnt_q == '0);
  assign bit_mode_o = mode_q;

  // R3/R11: outside readout the pixel generator must park phase 1 high
  a_r3_shift_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_READ) |-> phi1_i);

  // R10: captured clamp mode cannot move while a line is in progress
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_HOLD) |=> $stable(mode_q));

endmodule

// File: rtl/ccdt_pix_gen.sv
module ccdt_pix_gen #(
  parameter int HALF_TK    = 24,
  parameter int NPIX       = 3754,
  parameter int RST_DLY_TK = 1,
  parameter int RST_TK     = 6,
  parameter int CLP_GAP_TK = 1,
  parameter int CLP_TK     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic bit_mode_i,
  output logic phi1_o,
  output logic rgate_o,
  output logic clamp_o,
  output logic done_o
);

  localparam int HC_W = $clog2(HALF_TK + 1);
  localparam int PX_W = $clog2(NPIX + 1);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_TK - 1);
  localparam logic [PX_W-1:0] PX_LAST = PX_W'(NPIX - 1);
  localparam logic [HC_W-1:0] RS_LO   = HC_W'(RST_DLY_TK);
  localparam logic [HC_W-1:0] RS_HI   = HC_W'(RST_DLY_TK + RST_TK);
  localparam logic [HC_W-1:0] CP_LO   = HC_W'(RST_DLY_TK + RST_TK + CLP_GAP_TK);
  localparam logic [HC_W-1:0] CP_HI   = HC_W'(RST_DLY_TK + RST_TK + CLP_GAP_TK + CLP_TK);

  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic [PX_W-1:0] hidx_q, hidx_d;
  logic            half_end;

  assign half_end = (hcnt_q == HC_LAST);

  always_comb begin
    hcnt_d = hcnt_q;
    hidx_d = hidx_q;
    if (!run_i) begin
      hcnt_d = '0;
      hidx_d = '0;
    end else if (half_end) begin
      hcnt_d = '0;
      hidx_d = (hidx_q == PX_LAST) ? '0 : hidx_q + PX_W'(1);
    end else begin
      hcnt_d = hcnt_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      hidx_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      hidx_q <= hidx_d;
    end
  end

  // first half-period drives phase 1 low; an even count ends high
  assign phi1_o  = run_i ? hidx_q[0] : 1'b1;
  assign rgate_o = run_i && (hcnt_q >= RS_LO) && (hcnt_q < RS_HI);
  assign clamp_o = run_i && bit_mode_i && (hcnt_q >= CP_LO) && (hcnt_q < CP_HI);
  assign done_o  = run_i && half_end && (hidx_q == PX_LAST);

  // R7: a reset pulse never starts in the tick that moves the phase
  a_r7_reset_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rgate_o) |-> $stable(phi1_o));

endmodule

// File: rtl/ccd_clkgen.sv
module ccd_clkgen
  import ccdt_pkg::*;
#(
  parameter int LP_W       = 24,
  parameter int GUARD_TK   = 15,
  parameter int XFER_TK    = 75,
  parameter int HALF_TK    = 24,
  parameter int NPIX       = 3754,
  parameter int RST_DLY_TK = 1,
  parameter int RST_TK     = 6,
  parameter int CLP_GAP_TK = 1,
  parameter int CLP_TK     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clamp_mode_i,
  input  logic [LP_W-1:0] line_period_i,
  output logic            xfer_o,
  output logic            phi1_o,
  output logic            phi2_o,
  output logic            phi2l_o,
  output logic            rst_gate_o,
  output logic            clamp_o,
  output logic            line_start_o
);

  logic   rst_sync_n;
  logic   expire;
  logic   idle, run, seq_xfer, seq_lstart, bit_mode;
  logic   pix_phi1, pix_rgate, pix_clamp, pix_done;
  phase_e phase;
  drv_s   drv_d, drv_q;

  ccdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ccdt_line_timer #(.LP_W(LP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .period_i (line_period_i),
    .idle_i   (idle),
    .expire_o (expire)
  );

  ccdt_phase_seq #(.GUARD_TK(GUARD_TK), .XFER_TK(XFER_TK)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .expire_i    (expire),
    .mode_i      (clamp_mode_i),
    .read_done_i (pix_done),
    .phi1_i      (pix_phi1),
    .phase_o     (phase),
    .idle_o      (idle),
    .run_o       (run),
    .xfer_o      (seq_xfer),
    .lstart_o    (seq_lstart),
    .bit_mode_o  (bit_mode)
  );

  ccdt_pix_gen #(
    .HALF_TK    (HALF_TK),
    .NPIX       (NPIX),
    .RST_DLY_TK (RST_DLY_TK),
    .RST_TK     (RST_TK),
    .CLP_GAP_TK (CLP_GAP_TK),
    .CLP_TK     (CLP_TK)
  ) u_pix (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run_i      (run),
    .bit_mode_i (bit_mode),
    .phi1_o     (pix_phi1),
    .rgate_o    (pix_rgate),
    .clamp_o    (pix_clamp),
    .done_o     (pix_done)
  );

  always_comb begin
    drv_d.xfer   = seq_xfer;
    drv_d.phi1   = pix_phi1;
    drv_d.phi2   = ~pix_phi1;
    drv_d.phi2l  = ~pix_phi1;
    drv_d.rgate  = pix_rgate;
    drv_d.clamp  = pix_clamp;
    drv_d.lstart = seq_lstart;
  end

  // single output stage keeps every drive line aligned to the same tick
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      drv_q <= '{xfer: 1'b0, phi1: 1'b1, phi2: 1'b0, phi2l: 1'b0,
                 rgate: 1'b0, clamp: 1'b0, lstart: 1'b0};
    else
      drv_q <= drv_d;
  end

  assign xfer_o       = drv_q.xfer;
  assign phi1_o       = drv_q.phi1;
  assign phi2_o       = drv_q.phi2;
  assign phi2l_o      = drv_q.phi2l;
  assign rst_gate_o   = drv_q.rgate;
  assign clamp_o      = drv_q.clamp;
  assign line_start_o = drv_q.lstart;

  a_r3_frozen_in_xfer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_o |-> (phi1_o && !phi2l_o && !rst_gate_o && !clamp_o));

  a_r8_reset_clamp_apart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rst_gate_o && clamp_o));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_start_o |=> !line_start_o);

  a_r9_line_mode_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bit_mode && phase == PH_READ) |=> !clamp_o);

endmodule

// File: tb/ccd_clkgen_tb_top.sv
module ccd_clkgen_tb_top;

  localparam int LP_W  = 24;
  localparam int G     = 4;
  localparam int TW    = 10;
  localparam int HALF  = 8;
  localparam int NPIX  = 6;
  localparam int RDLY  = 1;
  localparam int RW    = 2;
  localparam int CGAP  = 1;
  localparam int CW    = 2;
  localparam int TMIN  = 2*G + TW + NPIX*HALF + 1;

  localparam int VEC_N = 6;
  localparam int V_MODE [VEC_N] = '{1, 0, 1, 0, 1, 1};
  localparam int V_PER  [VEC_N] = '{100, 100, 20, 67, 66, 150};

  logic            clk;
  logic            rst_n;
  logic            mode_r;
  logic [LP_W-1:0] per_r;
  logic xfer, phi1, phi2, phi2l, rgate, clamp, lstart;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit finished = 0;

  ccd_clkgen #(
    .LP_W(LP_W), .GUARD_TK(G), .XFER_TK(TW), .HALF_TK(HALF), .NPIX(NPIX),
    .RST_DLY_TK(RDLY), .RST_TK(RW), .CLP_GAP_TK(CGAP), .CLP_TK(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clamp_mode_i(mode_r), .line_period_i(per_r),
    .xfer_o(xfer), .phi1_o(phi1), .phi2_o(phi2), .phi2l_o(phi2l),
    .rst_gate_o(rgate), .clamp_o(clamp), .line_start_o(lstart)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic wait_ls();
    do @(negedge clk); while (!lstart);
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " xfer"},   int'(xfer),   0);
    chk({tag, " phi1"},   int'(phi1),   1);
    chk({tag, " phi2"},   int'(phi2),   0);
    chk({tag, " phi2l"},  int'(phi2l),  0);
    chk({tag, " rgate"},  int'(rgate),  0);
    chk({tag, " clamp"},  int'(clamp),  0);
    chk({tag, " lstart"}, int'(lstart), 0);
  endtask

  // measure one complete line, from one strobe to the next
  task automatic measure(input int exp_int, input bit exp_bit,
                         input int flip_at, input bit flip_val);
    int k, got;
    int tg_rise, tg_fall, first_fall, edges, last_edge;
    int rs_cnt, rs_rise, rs_fall, cp_cnt, cp_rise;
    int bad_frz, bad_hold, bad_comp, bad_half, bad_rs, bad_cp, bad_ov;
    logic p_tg, p_phi1, p_rs, p_cp;
    wait_ls();
    k = 0; got = 0;
    tg_rise = -1; tg_fall = -1; first_fall = -1; edges = 0; last_edge = -1000;
    rs_cnt = 0; rs_rise = -1000; rs_fall = -1000; cp_cnt = 0; cp_rise = -1000;
    bad_frz = 0; bad_hold = 0; bad_comp = 0; bad_half = 0;
    bad_rs = 0; bad_cp = 0; bad_ov = 0;
    p_tg = xfer; p_phi1 = phi1; p_rs = rgate; p_cp = clamp;
    while (!got && k < 4000) begin
      if (xfer && !p_tg) tg_rise = k;
      if (!xfer && p_tg) tg_fall = k;
      if (phi1 != p_phi1) begin
        edges++;
        if (edges == 1) first_fall = phi1 ? -2 : k;
        else if (k - last_edge != HALF) bad_half++;
        last_edge = k;
      end
      if (rgate && !p_rs) begin
        rs_cnt++;
        rs_rise = k;
        if (k - last_edge != RDLY) bad_rs++;
      end
      if (!rgate && p_rs) begin
        rs_fall = k;
        if (k - rs_rise != RW) bad_rs++;
      end
      if (clamp && !p_cp) begin
        cp_cnt++;
        cp_rise = k;
        if (k - rs_fall != CGAP) bad_cp++;
      end
      if (!clamp && p_cp && (k - cp_rise != CW)) bad_cp++;
      if (rgate && clamp) bad_ov++;
      if ((phi2 != !phi1) || (phi2l != !phi1)) bad_comp++;
      if ((tg_fall < 0) || (k < tg_fall + G)) begin
        if (!phi1 || phi2 || phi2l || rgate || clamp) bad_frz++;
      end
      if ((tg_fall >= 0) && (k >= tg_fall + G + NPIX*HALF)) begin
        if (!phi1 || rgate || clamp) bad_hold++;
      end
      if (k == flip_at) mode_r = flip_val;
      p_tg = xfer; p_phi1 = phi1; p_rs = rgate; p_cp = clamp;
      @(negedge clk);
      k++;
      if (lstart) got = 1;
    end
    chk("R2 line spacing", got ? k : -1, exp_int);
    chk("R4 xfer rise after strobe", tg_rise, G);
    chk("R4 xfer width", tg_fall - tg_rise, TW);
    chk("R5 first phi1 fall after xfer", first_fall, tg_fall + G);
    chk("R5 phase edges per line", edges, NPIX);
    chk("R5 half-period length errors", bad_half, 0);
    chk("R6 complement errors", bad_comp, 0);
    chk("R3 freeze window errors", bad_frz, 0);
    chk("R11 post-readout hold errors", bad_hold, 0);
    chk("R7 reset pulses per line", rs_cnt, NPIX);
    chk("R7 reset placement errors", bad_rs, 0);
    chk("R8 reset/clamp overlap", bad_ov, 0);
    if (exp_bit) begin
      chk("R8 clamp pulses per line", cp_cnt, NPIX);
      chk("R8 clamp placement errors", bad_cp, 0);
    end else begin
      chk("R9 clamp pulses in line mode", cp_cnt, 0);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    mode_r = 1'b0;
    per_r  = LP_W'(100);
    repeat (4) @(negedge clk);
    chk_reset_state("R1 held");
    rst_n = 1'b1;

    // vector table walk: mode and period per line
    for (int v = 0; v < VEC_N; v++) begin
      @(negedge clk);
      mode_r = V_MODE[v][0];
      per_r  = LP_W'(V_PER[v]);
      wait_ls();
      measure((V_PER[v] > TMIN) ? V_PER[v] : TMIN, V_MODE[v][0], -1, 1'b0);
    end

    // R10: mode flipped mid-line must not affect the running line
    mode_r = 1'b0;
    per_r  = LP_W'(100);
    wait_ls();
    measure(100, 1'b0, 30, 1'b1);
    measure(100, 1'b1, -1, 1'b0);
    // R10 reverse direction: bit to line mid-line
    measure(100, 1'b1, 40, 1'b0);
    measure(100, 1'b0, -1, 1'b0);

    // R1: asynchronous reset in the middle of readout
    wait_ls();
    repeat (G + TW + G + 3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R1 async");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mode_r = 1'b1;
    wait_ls();
    measure(100, 1'b1, -1, 1'b0);

    summary();
  end

endmodule